// File: doc/BRIEF.md
# Alignment Run Sequencer

This block steps a linear scoring array through one local-alignment run. A start request moves it from idle into a single clear cycle. In that cycle the array is told to wipe its state, and both memory address registers and the two activity flags sit at zero. The block then reads the query, one character per cycle, from a synchronous memory with one cycle of read latency. Each returned character goes into its own slot of one wide register that feeds every cell. Next it raises a load strobe for exactly one cycle, so all cells take their query character together.

After the load, the subject is read from a second synchronous memory. Its characters reach the first cell of the array one per clock, each marked by a valid bit. When the last subject address has been issued, the block waits one cycle per array cell. This lets the final subject character leave the last cell. The sequencer then captures the peak score and its coordinates, which come from the external maximum tracker, and raises done. Done stays high as long as start is held. When start is released, the block returns to idle.

Top module: `align_run_seq`

## Requirements
- R1: After reset, and while idle with start low, the following are all low: done, arr_clear, load_pulse, both read enables, awake, process and subj_valid. The query register and the peak outputs read zero.
- R2: Start seen high while idle causes exactly one following cycle in which arr_clear is high, awake and process are low, and both memory addresses are zero.
- R3: In the N_CELLS cycles right after the clear cycle, q_mem_rd is high and q_mem_addr counts 0, 1, … N_CELLS-1, one step per cycle.
- R4: The character returned for query address k is held in query_flat bits [k*CHAR_W +: CHAR_W]. Cell 0 therefore occupies the least significant bits.
- R5: load_pulse is high for exactly one cycle, two cycles after the last query address. In that cycle query_flat holds every query character.
- R6: In the cycle after load_pulse, s_mem_rd goes high and s_mem_addr counts 0 … SUBJ_LEN-1 on consecutive cycles. Then the read enable drops.
- R7: subj_valid is high exactly in the cycle after each subject read, SUBJ_LEN contiguous cycles in all. In those cycles subj_char equals the word the subject memory returns.
- R8: done first rises N_CELLS cycles after the last cycle with subj_valid high, and never earlier.
- R9: While done is high, peak_score, peak_cell and peak_pos hold the values on the peak inputs in the cycle before done first rose.
- R10: done stays high while start stays high. In the cycle after a cycle of done with start low, the block is idle and done is low.
- R11: awake is high from the first query read through the last drain cycle. process is high from the first subject read through the last drain cycle. Both are low in idle, clear and done cycles.
- R12: Once a run has begun, dropping start has no effect on the run's timing or outputs until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run from idle; holds done |
| q_mem_rd | output | 1 | Query memory read enable |
| q_mem_addr | output | QAW | Query memory address |
| q_mem_data | input | CHAR_W | Query memory read data, one cycle after address |
| s_mem_rd | output | 1 | Subject memory read enable |
| s_mem_addr | output | SAW | Subject memory address |
| s_mem_data | input | CHAR_W | Subject memory read data, one cycle after address |
| pk_score_in | input | SCORE_W | Running peak score from the max tracker |
| pk_cell_in | input | QAW | Cell index of the running peak |
| pk_pos_in | input | SAW | Subject position of the running peak |
| arr_clear | output | 1 | Array clear strobe, high in the clear cycle |
| awake | output | 1 | Run active flag |
| process | output | 1 | Subject pipeline active flag |
| load_pulse | output | 1 | One-cycle query capture strobe |
| query_flat | output | N_CELLS*CHAR_W | Packed query characters, one slot per cell |
| subj_char | output | CHAR_W | Subject character into the first cell |
| subj_valid | output | 1 | Marks a valid subject character |
| done | output | 1 | Run finished; peak outputs valid |
| peak_score | output | SCORE_W | Captured peak score |
| peak_cell | output | QAW | Captured peak cell index |
| peak_pos | output | SAW | Captured peak subject position |

## Verification
The bench builds the block with N_CELLS=4, SUBJ_LEN=6, CHAR_W=2 and SCORE_W=21. With these values a whole run, including the four-cycle drain, takes about twenty cycles. The cycle-by-cycle model can then compare every address, strobe and flag on every clock of two back-to-back runs. The small array makes the 3-bit query counter pass its end value and the subject counter stop short of a power of two. It also lets both the held-done release and the early start release be reached within one short test.

// File: rtl/arq_pkg.sv
`timescale 1ns/1ps
package arq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RESET,
        PH_LOADQ,
        PH_PULSE,
        PH_STREAM,
        PH_DRAIN,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic awake;
        logic process;
    } run_flags_t;

    function automatic run_flags_t flags_of(input phase_e p);
        run_flags_t f;
        f.awake   = (p == PH_LOADQ) || (p == PH_PULSE) ||
                    (p == PH_STREAM) || (p == PH_DRAIN);
        f.process = (p == PH_STREAM) || (p == PH_DRAIN);
        return f;
    endfunction

    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/arq_phase_fsm.sv
`timescale 1ns/1ps
module arq_phase_fsm
    import arq_pkg::*;
#(
    parameter int N_CELLS = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   q_all_issued,
    input  logic   s_last_issue,
    output phase_e phase,
    output logic   drain_last
);
    localparam int DCW = addr_bits(N_CELLS);
    localparam logic [DCW-1:0] DLAST = DCW'(N_CELLS - 1);

    logic [DCW-1:0] dcnt;
    phase_e         nxt;

    assign drain_last = (phase == PH_DRAIN) && (dcnt == DLAST);

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE:   if (start)        nxt = PH_RESET;
            PH_RESET:                    nxt = PH_LOADQ;
            PH_LOADQ:  if (q_all_issued) nxt = PH_PULSE;
            PH_PULSE:                    nxt = PH_STREAM;
            PH_STREAM: if (s_last_issue) nxt = PH_DRAIN;
            PH_DRAIN:  if (drain_last)   nxt = PH_DONE;
            PH_DONE:   if (!start)       nxt = PH_IDLE;
            default:                     nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            dcnt  <= '0;
        end else begin
            phase <= nxt;
            dcnt  <= (phase == PH_DRAIN && !drain_last) ? dcnt + 1'b1 : '0;
        end
    end

    // R12
    stream_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STREAM && !s_last_issue) |=> (phase == PH_STREAM));

endmodule

// File: rtl/arq_query_loader.sv
`timescale 1ns/1ps
module arq_query_loader
    import arq_pkg::*;
#(
    parameter int N_CELLS = 16,
    parameter int CHAR_W  = 2,
    localparam int QAW    = addr_bits(N_CELLS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      active,
    input  logic [CHAR_W-1:0]         mem_data,
    output logic                      mem_rd,
    output logic [QAW-1:0]            mem_addr,
    output logic                      all_issued,
    output logic [N_CELLS*CHAR_W-1:0] flat
);
    localparam int QCW = $clog2(N_CELLS + 1);
    localparam logic [QCW-1:0] CEND = QCW'(N_CELLS);

    logic [QCW-1:0] cnt;
    logic           vld_d;
    logic [QAW-1:0] idx_d;

    assign mem_rd     = active && (cnt != CEND);
    assign all_issued = active && (cnt == CEND);
    assign mem_addr   = cnt[QAW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            vld_d <= 1'b0;
            idx_d <= '0;
        end else begin
            cnt   <= mem_rd ? cnt + 1'b1 : (active ? cnt : '0);
            vld_d <= mem_rd;
            idx_d <= mem_addr;
        end
    end

    for (genvar g = 0; g < N_CELLS; g++) begin : g_slot
        logic [CHAR_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (vld_d && idx_d == QAW'(g))
                q <= mem_data;
        end
        assign flat[g*CHAR_W +: CHAR_W] = q;
    end

    // R3
    q_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + 1'b1));

endmodule

// File: rtl/arq_subject_streamer.sv
`timescale 1ns/1ps
module arq_subject_streamer
    import arq_pkg::*;
#(
    parameter int SUBJ_LEN = 32,
    parameter int CHAR_W   = 2,
    localparam int SAW     = addr_bits(SUBJ_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [CHAR_W-1:0] mem_data,
    output logic              mem_rd,
    output logic [SAW-1:0]    mem_addr,
    output logic              last_issue,
    output logic [CHAR_W-1:0] subj_char,
    output logic              subj_valid
);
    localparam int SCW = $clog2(SUBJ_LEN + 1);
    localparam logic [SCW-1:0] SLAST = SCW'(SUBJ_LEN - 1);

    logic [SCW-1:0] cnt;

    assign mem_rd     = active;
    assign last_issue = active && (cnt == SLAST);
    assign mem_addr   = cnt[SAW-1:0];
    assign subj_char  = subj_valid ? mem_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            subj_valid <= 1'b0;
        end else begin
            cnt        <= active ? cnt + 1'b1 : '0;
            subj_valid <= mem_rd;
        end
    end

    // R7
    s_valid_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> subj_valid);

    // R6
    s_stop_chk: assert property (@(posedge clk) disable iff (rst)
        last_issue |=> !mem_rd);

endmodule

// File: rtl/align_run_seq.sv
`timescale 1ns/1ps
module align_run_seq
    import arq_pkg::*;
#(
    parameter int N_CELLS  = 16,
    parameter int SUBJ_LEN = 32,
    parameter int CHAR_W   = 2,
    parameter int SCORE_W  = 21,
    localparam int QAW     = addr_bits(N_CELLS),
    localparam int SAW     = addr_bits(SUBJ_LEN)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    output logic                      q_mem_rd,
    output logic [QAW-1:0]            q_mem_addr,
    input  logic [CHAR_W-1:0]         q_mem_data,
    output logic                      s_mem_rd,
    output logic [SAW-1:0]            s_mem_addr,
    input  logic [CHAR_W-1:0]         s_mem_data,
    input  logic [SCORE_W-1:0]        pk_score_in,
    input  logic [QAW-1:0]            pk_cell_in,
    input  logic [SAW-1:0]            pk_pos_in,
    output logic                      arr_clear,
    output logic                      awake,
    output logic                      process,
    output logic                      load_pulse,
    output logic [N_CELLS*CHAR_W-1:0] query_flat,
    output logic [CHAR_W-1:0]         subj_char,
    output logic                      subj_valid,
    output logic                      done,
    output logic [SCORE_W-1:0]        peak_score,
    output logic [QAW-1:0]            peak_cell,
    output logic [SAW-1:0]            peak_pos
);
    phase_e     phase;
    logic       drain_last;
    logic       q_all_issued;
    logic       s_last_issue;
    run_flags_t flags;

    arq_phase_fsm #(.N_CELLS(N_CELLS)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .q_all_issued (q_all_issued),
        .s_last_issue (s_last_issue),
        .phase        (phase),
        .drain_last   (drain_last)
    );

    arq_query_loader #(.N_CELLS(N_CELLS), .CHAR_W(CHAR_W)) u_qload (
        .clk        (clk),
        .rst        (rst),
        .active     (phase == PH_LOADQ),
        .mem_data   (q_mem_data),
        .mem_rd     (q_mem_rd),
        .mem_addr   (q_mem_addr),
        .all_issued (q_all_issued),
        .flat       (query_flat)
    );

    arq_subject_streamer #(.SUBJ_LEN(SUBJ_LEN), .CHAR_W(CHAR_W)) u_sfeed (
        .clk        (clk),
        .rst        (rst),
        .active     (phase == PH_STREAM),
        .mem_data   (s_mem_data),
        .mem_rd     (s_mem_rd),
        .mem_addr   (s_mem_addr),
        .last_issue (s_last_issue),
        .subj_char  (subj_char),
        .subj_valid (subj_valid)
    );

    assign flags      = flags_of(phase);
    assign awake      = flags.awake;
    assign process    = flags.process;
    assign arr_clear  = (phase == PH_RESET);
    assign load_pulse = (phase == PH_PULSE);
    assign done       = (phase == PH_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            peak_score <= '0;
            peak_cell  <= '0;
            peak_pos   <= '0;
        end else if (drain_last) begin
            peak_score <= pk_score_in;
            peak_cell  <= pk_cell_in;
            peak_pos   <= pk_pos_in;
        end
    end

    // R2
    clr_addr_chk: assert property (@(posedge clk) disable iff (rst)
        arr_clear |-> (q_mem_addr == '0 && s_mem_addr == '0 && !awake));

    // R5
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        load_pulse |=> !load_pulse);

    // R11
    proc_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(process) |-> $past(load_pulse));

    // R8
    done_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(process));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> done);

    // R9
    peak_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> ($stable(peak_score) && $stable(peak_pos)));

endmodule

// File: tb/test_align_run_seq.sv
`timescale 1ns/1ps
module test_align_run_seq;
    localparam int N   = 4;
    localparam int S   = 6;
    localparam int CW  = 2;
    localparam int SW  = 21;
    localparam int QAW = 2;
    localparam int SAW = 3;

    logic            clk, rst, start;
    logic            q_rd, s_rd;
    logic [QAW-1:0]  q_addr;
    logic [SAW-1:0]  s_addr;
    logic [CW-1:0]   q_data, s_data;
    logic [SW-1:0]   pk_score;
    logic [QAW-1:0]  pk_cell;
    logic [SAW-1:0]  pk_pos;
    logic            arr_clear, awake, process, load_pulse, subj_valid, done;
    logic [N*CW-1:0] query_flat;
    logic [CW-1:0]   subj_char;
    logic [SW-1:0]   peak_score;
    logic [QAW-1:0]  peak_cell;
    logic [SAW-1:0]  peak_pos;

    align_run_seq #(.N_CELLS(N), .SUBJ_LEN(S), .CHAR_W(CW), .SCORE_W(SW)) i_align_run_seq (
        .clk(clk), .rst(rst), .start(start),
        .q_mem_rd(q_rd), .q_mem_addr(q_addr), .q_mem_data(q_data),
        .s_mem_rd(s_rd), .s_mem_addr(s_addr), .s_mem_data(s_data),
        .pk_score_in(pk_score), .pk_cell_in(pk_cell), .pk_pos_in(pk_pos),
        .arr_clear(arr_clear), .awake(awake), .process(process),
        .load_pulse(load_pulse), .query_flat(query_flat),
        .subj_char(subj_char), .subj_valid(subj_valid), .done(done),
        .peak_score(peak_score), .peak_cell(peak_cell), .peak_pos(peak_pos)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [CW-1:0] qmem [N];
    logic [CW-1:0] smem [S];

    always @(posedge clk) begin
        if (q_rd) q_data <= qmem[q_addr];
        if (s_rd) s_data <= smem[s_addr];
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint pk_of(input int c, input int run);
        return longint'(1000 + 7 * c + 3 * run);
    endfunction

    task automatic idle_checks();
        chk("R1", "done", done, 0);
        chk("R1", "arr_clear", arr_clear, 0);
        chk("R1", "load_pulse", load_pulse, 0);
        chk("R1", "q_mem_rd", q_rd, 0);
        chk("R1", "s_mem_rd", s_rd, 0);
        chk("R1", "awake", awake, 0);
        chk("R1", "process", process, 0);
        chk("R1", "subj_valid", subj_valid, 0);
    endtask

    task automatic run_one(input int run, input int drop_at, input int last_c);
        int pul, ss, dend, dn;
        bit dexp, sprev;
        longint ef;
        pul  = N + 2;
        ss   = N + 3;
        dend = 2 * N + 2 + S;
        dn   = dend + 1;
        ef   = 0;
        for (int k = 0; k < N; k++) begin
            qmem[k] = CW'((k * 3 + run) % 4);
            ef |= longint'(qmem[k]) << (k * CW);
        end
        for (int k = 0; k < S; k++) smem[k] = CW'((k * 5 + run * 2 + 1) % 4);
        dexp  = 1'b0;
        sprev = 1'b1;
        @(negedge clk);
        start = 1'b1;
        for (int c = 0; c <= last_c; c++) begin
            @(negedge clk);
            if (c == dn) dexp = 1'b1;
            else if (c > dn) dexp = dexp && sprev;
            chk("R2", "arr_clear", arr_clear, (c == 0));
            if (c == 0) begin
                chk("R2", "q addr in clear", q_addr, 0);
                chk("R2", "s addr in clear", s_addr, 0);
            end
            chk("R3", "q_mem_rd", q_rd, (c >= 1 && c <= N));
            if (c >= 1 && c <= N) chk("R3", "q_mem_addr", q_addr, c - 1);
            chk("R5", "load_pulse", load_pulse, (c == pul));
            if (c == pul) chk("R4", "query_flat", query_flat, ef);
            chk("R6", "s_mem_rd", s_rd, (c >= ss && c < ss + S));
            if (c >= ss && c < ss + S) chk("R6", "s_mem_addr", s_addr, c - ss);
            chk("R7", "subj_valid", subj_valid, (c > ss && c <= ss + S));
            if (c > ss && c <= ss + S) chk("R7", "subj_char", subj_char, smem[c - ss - 1]);
            chk("R11", "awake", awake, (c >= 1 && c <= dend));
            chk("R11", "process", process, (c >= ss && c <= dend));
            if (c <= dn) chk("R8", "done", done, dexp);
            else         chk("R10", "done", done, dexp);
            if (run == 2 && c == dn) chk("R12", "done after early start drop", done, 1);
            if (dexp) begin
                chk("R9", "peak_score", peak_score, pk_of(dend, run));
                chk("R9", "peak_cell", peak_cell, dend % N);
                chk("R9", "peak_pos", peak_pos, dend % S);
            end
            pk_score = SW'(pk_of(c, run));
            pk_cell  = QAW'(c % N);
            pk_pos   = SAW'(c % S);
            if (c == drop_at) start = 1'b0;
            sprev = start;
        end
        start = 1'b0;
    endtask

    initial begin
        rst      = 1'b1;
        start    = 1'b0;
        pk_score = '0;
        pk_cell  = '0;
        pk_pos   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            idle_checks();
        end
        chk("R1", "query_flat after reset", query_flat, 0);
        chk("R1", "peak_score after reset", peak_score, 0);
        // run 1: start held through done for a few cycles, then released
        run_one(1, 2 * N + 3 + S + 3, 2 * N + 3 + S + 5);
        @(negedge clk);
        idle_checks();
        // run 2: start dropped early in the run (R12)
        run_one(2, 3, 2 * N + 3 + S + 2);
        @(negedge clk);
        idle_checks();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule